// File: doc/BRIEF.md
# Capture Event Interrupt Flag Controller

This block gathers the event strobes of an edge-capture unit (rising-edge capture, falling-edge capture and capture-counter overflow) and keeps a sticky flag for each. A further flag, the rising overrun, records that a new rising capture arrived while the previous rising flag was still unacknowledged. Software sees the flags through a small register interface. It can enable the interrupt sources, clear flags by writing ones, and set flags by writing ones for test.

A global flag stands in front of the interrupt output. When any enabled flag is pending and the global flag is low, the block issues one registered single-cycle pulse to the system interrupt controller and sets the global flag. No further pulse leaves the block until software clears the global flag. If sources are still pending at that point, the block pulses again at once.

Top module: `capevt_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every flag and every enable is 0 and the interrupt pulse output is 0.
- R2: A rise, fall or overflow strobe sets its flag (status bits 1, 2, 3 respectively) at the next clock edge. The flag then stays set until it is cleared, whatever the enables are.
- R3: A rising strobe, or a forced rise, that arrives while the rise flag is already 1 sets the rising-overrun flag (status bit 4).
- R4: A write to the clear register (address 2) clears each flag whose bit is written as 1, using the status bit layout. Bits written as 0 leave their flags unchanged.
- R5: A write to the force register (address 3) sets the rise, fall and overflow flags whose bits (1, 2, 3) are 1. Bits 0 and 4 of a force write have no effect.
- R6: When a strobe or force and a clear hit the same flag in the same cycle, the flag ends up set.
- R7: Control register (address 0) bit 0 enables the rise and rising-overrun flags onto the interrupt path, bit 1 the fall flag, and bit 2 the overflow flag. A pending flag whose enable is 0 never causes a pulse.
- R8: With an enabled flag pending and the global flag (status bit 0) at 0, the interrupt output is high for exactly one cycle, one clock after the pending flag is visible. The global flag becomes 1 in that same cycle.
- R9: While the global flag is 1, no pulse is issued. Only writing 1 to bit 0 of the clear register clears it. If enabled flags are still pending, a new single pulse follows one cycle after the global flag reads 0.
- R10: Reads return the enables in bits 2:0 at address 0 and the status at address 1. Addresses 2 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_rise_i | input | 1 | Rising-edge capture strobe |
| evt_fall_i | input | 1 | Falling-edge capture strobe |
| evt_ovf_i | input | 1 | Capture counter overflow strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 status, 2 clear, 3 force) |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational on the address |
| flags_o | output | 5 | Status: bit 0 global, 1 rise, 2 fall, 3 overflow, 4 rising overrun |
| irq_pulse_o | output | 1 | Single-cycle interrupt pulse |

## Verification
Two things can land in the same cycle: a hardware strobe that sets a flag and a software clear aimed at that same flag. The bench drives a rise strobe and a fall strobe in the very cycle that a clear register write names those bits. It then checks that both flags stay set. Because the rise flag was already set, the overrun flag must come up as well. A second overlap is also covered: the global flag is cleared while a source is still pending, and the bench judges the re-issued pulse by its exact cycle and by the requirement that it is high for one cycle only.

// File: rtl/capevt_pkg.sv
package capevt_pkg;

    // number of hardware event sources: rise, fall, overflow
    localparam int NSRC  = 3;
    // status layout: global, three sources, rising overrun
    localparam int NFLAG = NSRC + 2;

    localparam int S_RISE = 0;
    localparam int S_FALL = 1;
    localparam int S_OVF  = 2;

    localparam int B_GLB  = 0;
    localparam int B_SRC0 = 1;
    localparam int B_ROVR = B_SRC0 + NSRC;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_CLR  = 2'd2,
        A_FRC  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [NSRC-1:0] src;
        logic            ovr;
    } flag_st_t;

    typedef struct packed {
        logic glob;
        logic pulse;
    } irq_st_t;

    typedef struct packed {
        logic [NSRC-1:0] en;
    } ctl_st_t;

endpackage

// File: rtl/capevt_regif.sv
module capevt_regif
    import capevt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [NFLAG-1:0] status_i,
    output logic [NSRC-1:0]  en_o,
    output logic [NFLAG-1:0] clr_o,
    output logic [NSRC-1:0]  frc_o,
    output logic [DW-1:0]    rdata_o
);

    ctl_st_t st_d, st_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        frc_o = '0;
        if (wr_i) begin
            case (reg_addr_e'(addr_i))
                A_CTRL:  st_d.en = wdata_i[NSRC-1:0];
                A_CLR:   clr_o   = wdata_i[NFLAG-1:0];
                A_FRC:   frc_o   = wdata_i[B_SRC0 +: NSRC];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (reg_addr_e'(addr_i))
            A_CTRL:  rdata_o[NSRC-1:0]  = st_q.en;
            A_STAT:  rdata_o[NFLAG-1:0] = status_i;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

    // R7
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 2'd0) |=> (en_o == $past(wdata_i[NSRC-1:0])));

endmodule

// File: rtl/capevt_flag_bank.sv
module capevt_flag_bank
    import capevt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hw_evt_i,
    input  logic [NSRC-1:0] frc_i,
    input  logic [NSRC-1:0] clr_src_i,
    input  logic            clr_ovr_i,
    output logic [NSRC-1:0] src_o,
    output logic            ovr_o
);

    flag_st_t        st_d, st_q;
    logic [NSRC-1:0] set_w;
    logic            ovr_set;

    for (genvar g = 0; g < NSRC; g++) begin : g_set
        assign set_w[g] = hw_evt_i[g] | frc_i[g];
    end

    // a new rise while the previous one is unacknowledged
    assign ovr_set = set_w[S_RISE] & st_q.src[S_RISE];

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            if (set_w[i])          st_d.src[i] = 1'b1;
            else if (clr_src_i[i]) st_d.src[i] = 1'b0;
        end
        if (ovr_set)        st_d.ovr = 1'b1;
        else if (clr_ovr_i) st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_o = st_q.src;
    assign ovr_o = st_q.ovr;

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_w != '0) |=> ((src_o & $past(set_w)) == $past(set_w)));

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_src_i[S_FALL] && !set_w[S_FALL]) |=> !src_o[S_FALL]);

    // R3
    rise_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_w[S_RISE] && src_o[S_RISE]) |=> ovr_o);

endmodule

// File: rtl/capevt_irq_gen.sv
module capevt_irq_gen
    import capevt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            ovr_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            clr_glb_i,
    output logic            glob_o,
    output logic            pulse_o
);

    irq_st_t st_d, st_q;
    logic    pend;

    // overrun shares the rise enable
    assign pend = (|(src_i & en_i)) | (ovr_i & en_i[S_RISE]);

    always_comb begin
        st_d       = st_q;
        st_d.pulse = pend & ~st_q.glob;
        if (st_d.pulse)     st_d.glob = 1'b1;
        else if (clr_glb_i) st_d.glob = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign glob_o  = st_q.glob;
    assign pulse_o = st_q.pulse;

    // R8
    one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    // R8
    pulse_sets_glob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> glob_o);

    // R9
    glob_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_o && !clr_glb_i) |=> glob_o);

endmodule

// File: rtl/capevt_irq_ctrl.sv
module capevt_irq_ctrl
    import capevt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_rise_i,
    input  logic          evt_fall_i,
    input  logic          evt_ovf_i,
    input  logic          reg_wr_i,
    input  logic [1:0]    reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic [4:0]    flags_o,
    output logic          irq_pulse_o
);

    logic [NSRC-1:0]  hw_evt;
    logic [NSRC-1:0]  en;
    logic [NSRC-1:0]  frc;
    logic [NFLAG-1:0] clr;
    logic [NFLAG-1:0] status;
    logic [NSRC-1:0]  src;
    logic             ovr;
    logic             glob;
    logic             pulse;

    always_comb begin
        hw_evt         = '0;
        hw_evt[S_RISE] = evt_rise_i;
        hw_evt[S_FALL] = evt_fall_i;
        hw_evt[S_OVF]  = evt_ovf_i;
    end

    capevt_regif #(.DW(DW)) i_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .status_i (status),
        .en_o     (en),
        .clr_o    (clr),
        .frc_o    (frc),
        .rdata_o  (reg_rdata_o)
    );

    capevt_flag_bank i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_evt_i  (hw_evt),
        .frc_i     (frc),
        .clr_src_i (clr[B_SRC0 +: NSRC]),
        .clr_ovr_i (clr[B_ROVR]),
        .src_o     (src),
        .ovr_o     (ovr)
    );

    capevt_irq_gen i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .ovr_i     (ovr),
        .en_i      (en),
        .clr_glb_i (clr[B_GLB]),
        .glob_o    (glob),
        .pulse_o   (pulse)
    );

    always_comb begin
        status                  = '0;
        status[B_GLB]           = glob;
        status[B_SRC0 +: NSRC]  = src;
        status[B_ROVR]          = ovr;
    end

    assign flags_o     = status;
    assign irq_pulse_o = pulse;

    // R7
    pulse_needs_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse_o |-> $past(((src & en) != '0) || (ovr && en[S_RISE])));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (flags_o == '0 && !irq_pulse_o));

endmodule

// File: tb/test_capevt_irq_ctrl.sv
module test_capevt_irq_ctrl;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_r = 1'b0, ev_f = 1'b0, ev_o = 1'b0;
    logic          wr = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [4:0]    flags;
    logic          irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    capevt_irq_ctrl #(.DW(DW)) i_capevt_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_rise_i  (ev_r),
        .evt_fall_i  (ev_f),
        .evt_ovf_i   (ev_o),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .flags_o     (flags),
        .irq_pulse_o (irq)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(logic [1:0] a, logic [DW-1:0] d);
        addr = a; wdata = d; wr = 1'b1;
        step();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic strobe(logic r, logic f, logic o);
        ev_r = r; ev_f = f; ev_o = o;
        step();
        ev_r = 1'b0; ev_f = 1'b0; ev_o = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 flags", flags, 5'b00000);
        chk("R1 pulse", irq, 1'b0);
        addr = 2'd0; #1;
        chk("R1 enables", rdata, 8'h00);
    endtask

    task automatic t_latch_and_clear();
        do_reset();
        strobe(1, 0, 0);
        chk("R2 rise", flags, 5'b00010);
        strobe(0, 1, 0);
        chk("R2 fall", flags, 5'b00110);
        strobe(0, 0, 1);
        chk("R2 ovf", flags, 5'b01110);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R7 no pulse when disabled", irq, 1'b0);
        end
        chk("R2 sticky", flags, 5'b01110);
        wreg(2'd2, 8'h00);
        chk("R4 zero write", flags, 5'b01110);
        wreg(2'd2, 8'b00100);
        chk("R4 clear fall", flags, 5'b01010);
        wreg(2'd2, 8'b01010);
        chk("R4 clear rest", flags, 5'b00000);
    endtask

    task automatic t_force();
        do_reset();
        wreg(2'd3, 8'b10001);
        chk("R5 bits 0 and 4 ignored", flags, 5'b00000);
        wreg(2'd3, 8'b01110);
        chk("R5 force three", flags, 5'b01110);
        wreg(2'd3, 8'b00010);
        chk("R3 forced rise overrun", flags, 5'b11110);
    endtask

    task automatic t_overrun();
        do_reset();
        strobe(1, 0, 0);
        chk("R3 first rise", flags, 5'b00010);
        strobe(1, 0, 0);
        chk("R3 overrun", flags, 5'b10010);
        wreg(2'd2, 8'b00010);
        chk("R4 overrun kept", flags, 5'b10000);
        wreg(2'd0, 8'b010);
        step();
        chk("R7 fall enable ignores overrun", irq, 1'b0);
        wreg(2'd0, 8'b001);
        chk("R7 pulse not yet", irq, 1'b0);
        step();
        chk("R7 overrun via rise enable", irq, 1'b1);
        chk("R8 global set", flags, 5'b10001);
    endtask

    task automatic t_pulse();
        do_reset();
        wreg(2'd0, 8'b100);
        strobe(0, 0, 1);
        chk("R8 flag before pulse", flags, 5'b01000);
        chk("R8 pulse latency", irq, 1'b0);
        step();
        chk("R8 pulse", irq, 1'b1);
        chk("R8 global", flags, 5'b01001);
        step();
        chk("R8 single cycle", irq, 1'b0);
        strobe(0, 0, 1);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R9 held off", irq, 1'b0);
        end
        wreg(2'd2, 8'b10110);
        chk("R9 global needs bit0", flags, 5'b01001);
        wreg(2'd2, 8'b00001);
        chk("R9 global cleared", flags, 5'b01000);
        chk("R9 no pulse yet", irq, 1'b0);
        step();
        chk("R9 re-pulse", irq, 1'b1);
        step();
        chk("R9 re-pulse single", irq, 1'b0);
        wreg(2'd2, 8'b01001);
        step(); step();
        chk("R9 idle after full clear", irq, 1'b0);
        chk("R9 flags clear", flags, 5'b00000);
    endtask

    task automatic t_collide();
        do_reset();
        strobe(1, 0, 0);
        ev_r = 1'b1; ev_f = 1'b1;
        addr = 2'd2; wdata = 8'b00110; wr = 1'b1;
        step();
        ev_r = 1'b0; ev_f = 1'b0; wr = 1'b0; wdata = '0;
        chk("R6 set beats clear", flags, 5'b10110);
    endtask

    task automatic t_read();
        do_reset();
        wreg(2'd0, 8'b101);
        addr = 2'd0; #1;
        chk("R10 control read", rdata, 8'h05);
        strobe(0, 1, 0);
        addr = 2'd1; #1;
        chk("R10 status read", rdata, 8'h04);
        addr = 2'd2; #1;
        chk("R10 clear reads 0", rdata, 8'h00);
        addr = 2'd3; #1;
        chk("R10 force reads 0", rdata, 8'h00);
    endtask

    initial begin
        t_reset();
        t_latch_and_clear();
        t_force();
        t_overrun();
        t_pulse();
        t_collide();
        t_read();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule